// File: doc/BRIEF.md
# Keyed Interrupt Priority Mask Filter

This block holds a four-bit interrupt mask level in a 32-bit register on a simple select/write register bus. It uses that level to filter a vector of pending interrupt requests before they reach the processor. Each request carries its own four-bit priority level. A request passes the filter only when it is pending, its level is not zero, and its level is strictly above the stored mask level. Low-urgency work can therefore be held off while urgent handling runs, without touching any other interrupt controller state.

A write only changes the mask when the top byte of the write data carries the key value 8'hA5. This guards against stray stores. The key byte and every reserved bit always read back as zero. The per-request enable vector is combinational from the stored mask and the request inputs. The combined request output is the OR of that vector, registered once so that it cannot glitch.

The register bus is a plain control interface with no back-pressure: an access completes in the cycle it is presented. Reads return data combinationally while the select input is high. The request inputs are sampled every cycle and are never stalled.

Top module: `keymask_filter`

## Requirements
- R1: A write with select and write enable high and write-data bits 31..24 equal to 8'hA5 loads write-data bits 7..4 into the mask level on that clock edge. Filtering uses the new level from the next cycle.
- R2: A write whose bits 31..24 differ from 8'hA5 leaves the mask level unchanged.
- R3: With select high, read data carries the mask level in bits 7..4, and bits 31..8 and 3..0 read as 0, even after a keyed write with all ones.
- R4: After reset the mask level is 0, read data with select is 32'h0, and the combined request output is 0.
- R5: Enable bit i is 1 exactly when request i is pending, its level (bits 4i+3..4i of the level bus) is nonzero, and that level is strictly greater than the mask level. A level equal to or below the mask is blocked.
- R6: A request with level 0 never passes, whatever the mask level.
- R7: With the mask level at 0, every pending request with a nonzero level passes.
- R8: The combined request output equals the OR of the enable vector of the previous cycle.
- R9: With select low, read data is 0 and a write, keyed or not, has no effect on the mask level.
- R10: With the mask level at 15, no request passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Address-decoded register select |
| reg_wr | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write data: key in 31..24, level in 7..4 |
| reg_rdata | output | 32 | Read data, 0 when not selected |
| req_pend | input | NUM_SRC | Pending request per source |
| req_lvl | input | 4*NUM_SRC | Priority level per source, source i in bits 4i+3..4i |
| req_en | output | NUM_SRC | Requests that pass the mask |
| irq_out | output | 1 | Registered OR of req_en |

## Verification
The bench builds the block with eight sources and the fixed key. With that build, one test can set all sixteen mask levels and, at each one, rotate all sixteen priority levels across the sources. Every pairing of mask level and request level then occurs on some source, including the equal-level boundary, level 0, and the two extreme mask levels. The bench also uses alternating pending patterns, near-miss key bytes, and writes with select low, so the key check and the select qualifier are each exercised alone.

// File: rtl/keymask_pkg.sv
package keymask_pkg;
  localparam int DATA_W   = 32;
  localparam int LVL_W    = 4;
  localparam int KEY_W    = 8;
  localparam int KEY_LSB  = DATA_W - KEY_W;
  localparam int MASK_LSB = 4;
  localparam logic [KEY_W-1:0] KEY_VAL = 8'hA5;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/keymask_reg.sv
module keymask_reg
  import keymask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  wr,
  input  logic [KEY_W-1:0] key_in,
  input  lvl_t  lvl_in,
  output lvl_t  mask_q,
  output word_t rdata
);
  logic key_ok;
  logic do_load;

  assign key_ok  = (key_in == KEY_VAL);
  assign do_load = sel && wr && key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (do_load) mask_q <= lvl_in;
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[MASK_LSB +: LVL_W] = mask_q;
  end
endmodule

// File: rtl/keymask_cmp.sv
module keymask_cmp
  import keymask_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  input  lvl_t                     mask,
  output logic [NUM_SRC-1:0]       en
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lvl_t src_lvl;
    assign src_lvl = lvl[g*LVL_W +: LVL_W];
    assign en[g]   = pend[g] && (src_lvl != '0) && (src_lvl > mask);
  end
endmodule

// File: rtl/keymask_irq.sv
module keymask_irq #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] en,
  output logic               irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |en;
  end
endmodule

// File: rtl/keymask_filter.sv
module keymask_filter
  import keymask_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_sel,
  input  logic                     reg_wr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_SRC-1:0]       req_pend,
  input  logic [NUM_SRC*4-1:0]     req_lvl,
  output logic [NUM_SRC-1:0]       req_en,
  output logic                     irq_out
);
  lvl_t mask_q;
  logic wdata_unused;

  assign wdata_unused = ^{reg_wdata[KEY_LSB-1:MASK_LSB+LVL_W], reg_wdata[MASK_LSB-1:0]};

  keymask_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (reg_sel),
    .wr     (reg_wr),
    .key_in (reg_wdata[KEY_LSB +: KEY_W]),
    .lvl_in (reg_wdata[MASK_LSB +: LVL_W]),
    .mask_q (mask_q),
    .rdata  (reg_rdata)
  );

  keymask_cmp #(.NUM_SRC(NUM_SRC)) u_cmp (
    .pend (req_pend),
    .lvl  (req_lvl),
    .mask (mask_q),
    .en   (req_en)
  );

  keymask_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (req_en),
    .irq_q (irq_out)
  );
endmodule

// File: rtl/keymask_filter_chk.sv
module keymask_filter_chk
  import keymask_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_sel,
  input logic                     reg_wr,
  input logic [31:0]              reg_wdata,
  input logic [31:0]              reg_rdata,
  input logic [NUM_SRC-1:0]       req_pend,
  input logic [NUM_SRC*4-1:0]     req_lvl,
  input logic [NUM_SRC-1:0]       req_en,
  input logic                     irq_out,
  input lvl_t                     mask_q
);
  logic [NUM_SRC-1:0] zero_lvl;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      zero_lvl[i] = (req_lvl[i*LVL_W +: LVL_W] == '0);
  end

  // R1
  keyed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_wdata[31:24] == KEY_VAL) |=> (mask_q == $past(reg_wdata[7:4])));

  // R2
  bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_wdata[31:24] != KEY_VAL) |=> $stable(mask_q));

  // R9
  no_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |=> $stable(mask_q));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:8] == '0) && (reg_rdata[3:0] == '0));

  // R5
  en_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en & ~req_pend) == '0);

  // R6
  zero_lvl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en & zero_lvl) == '0);

  // R10
  top_mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'hF) |-> (req_en == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|req_en)));
endmodule

bind keymask_filter keymask_filter_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .req_pend  (req_pend),
  .req_lvl   (req_lvl),
  .req_en    (req_en),
  .irq_out   (irq_out),
  .mask_q    (mask_q)
);

// File: tb/test_keymask_filter.sv
module test_keymask_filter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 200000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_sel = 1'b0;
  logic           reg_wr = 1'b0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic [N-1:0]   req_pend = '0;
  logic [N*4-1:0] req_lvl = '0;
  logic [N-1:0]   req_en;
  logic           irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keymask_filter #(.NUM_SRC(N)) i_keymask_filter (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_pend(req_pend),
    .req_lvl(req_lvl), .req_en(req_en), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic sel, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b0;
    #1;
    check(tag, reg_rdata, exp);
    reg_sel = 1'b0;
  endtask

  // driver: apply one request pattern and queue the expected result
  task automatic drive(input logic [3:0] mask, input logic [N-1:0] pend,
                       input logic [N*4-1:0] lvl, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req_pend = pend; req_lvl = lvl;
    for (int i = 0; i < N; i++) begin
      logic [3:0] l;
      l = lvl[i*4 +: 4];
      e[i] = pend[i] && (l != 4'd0) && (l > mask);
    end
    exp_q.push_back({|e, e});
    tag_q.push_back(tag);
  endtask

  // monitor: after the next rising edge req_en shows the pattern and irq_out its OR
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [N:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, req_en}, {24'd0, x[N-1:0]});
        check("R8", {31'd0, irq_out}, {31'd0, x[N]});
      end
    end
  end

  initial begin
    #(CLK_PERIOD*WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    reg_read(1'b1, "R4", 32'h0);
    check("R4", {31'd0, irq_out}, 32'd0);
    check("R4", {24'd0, req_en}, 32'd0);

    // R1 keyed write
    reg_write(1'b1, 32'hA500_0070);
    reg_read(1'b1, "R1", 32'h0000_0070);
    // R2 wrong keys
    reg_write(1'b1, 32'hA400_00F0);
    reg_read(1'b1, "R2", 32'h0000_0070);
    reg_write(1'b1, 32'h5A00_00F0);
    reg_read(1'b1, "R2", 32'h0000_0070);
    reg_write(1'b1, 32'hFF00_0030);
    reg_read(1'b1, "R2", 32'h0000_0070);
    reg_write(1'b1, 32'h0000_0030);
    reg_read(1'b1, "R2", 32'h0000_0070);
    // R3 all ones keyed
    reg_write(1'b1, 32'hA5FF_FFFF);
    reg_read(1'b1, "R3", 32'h0000_00F0);
    // R9 no select
    reg_read(1'b0, "R9", 32'h0);
    reg_write(1'b0, 32'hA500_0020);
    reg_read(1'b1, "R9", 32'h0000_00F0);

    // R1 new mask applies next cycle: write mask 2, requests at level 3 pass
    reg_write(1'b1, 32'hA500_0020);
    drive(4'd2, {N{1'b1}}, {N{4'd3}}, "R1");
    drive(4'd2, {N{1'b1}}, {N{4'd2}}, "R5");

    // sweep every mask level against rotating request levels
    for (int m = 0; m < 16; m++) begin
      string tg;
      reg_write(1'b1, {8'hA5, 16'h0, m[3:0], 4'h0});
      tg = (m == 0) ? "R7" : (m == 15) ? "R10" : "R5";
      for (int b = 0; b < 16; b++) begin
        logic [N*4-1:0] lv;
        for (int i = 0; i < N; i++) lv[i*4 +: 4] = 4'(b + i * 2 + (i & 1));
        drive(m[3:0], {N{1'b1}}, lv, tg);
        drive(m[3:0], (b[0] ? 8'h55 : 8'hAA), lv, tg);
      end
      // R6 all sources at level 0
      drive(m[3:0], {N{1'b1}}, '0, "R6");
    end
    drive(4'hF, '0, '0, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule